// File: doc/BRIEF.md
# Byte-Stream Sequence Packer for LZ-Style Block Compression

This block sits behind a match finder and turns its decisions into the byte stream of a block-format LZ4 compressor. The upstream side hands it one command per transfer: a literal byte to hold back, a back-reference (distance and length) that closes the current run of held literals, or an end marker that closes the block. For each accepted back-reference the block writes out one complete sequence: a token byte, the literal-length extension, the held literal bytes, the 16-bit distance, and the match-length extension. At the end marker it writes a closing sequence that carries only the remaining literals.

Literals wait in an internal store until the command that ends their run arrives, because the token that leads a sequence must already hold the literal count. While a sequence is being written out, the command port is stalled. The output is a byte-wide valid/ready stream whose last flag marks the final byte of each block. Back-references that cannot be encoded are dropped without any trace in the output.

Top module: `lz4_seq_packer`

## Requirements
- R1: An accepted back-reference produces one sequence, with its fields in this order: token, literal-length extension bytes, held literals, distance low byte, distance high byte, match-length extension bytes.
- R2: The token's upper nibble (bits 7:4) is the held-literal count capped at 15. Its lower nibble (bits 3:0) is the match length minus 4, capped at 15.
- R3: A nibble that holds 15 is followed by extension bytes for the value minus 15: a byte of 255 for each full 255, then one byte with the remainder (0 to 254), so an exact multiple of 255 ends in a zero byte.
- R4: Literal bytes leave in the order in which they were accepted.
- R5: in_kind 2 (end) produces a closing sequence: a token whose lower nibble is 0, any literal-length extension, and the held literals, with no distance and no match extension. out_last is high on the final byte of that sequence and on no other byte. With no held literals the closing sequence is the single byte 0x00.
- R6: A back-reference (in_kind 1) with distance 0, distance at or above OFS_LIMIT, or length below 4 is consumed and dropped. So is in_kind 3. Neither produces output, and the held literals stay pending.
- R7: A literal (in_kind 0) is refused while the store holds LIT_DEPTH bytes. in_ready is low for every kind while a sequence is being written out.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold their values until the byte is taken.
- R9: A block of n literals with no back-references produces at most n + n/255 + 16 bytes.
- R10: After reset, out_valid is low, no literals are held, and a literal is accepted at once.
- R11: Decoding the output with a standard LZ4 block decoder reproduces the accepted literal bytes and the copies described by the accepted back-references, byte for byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command accepted on this cycle when in_valid is high |
| in_kind | input | 2 | 0 literal, 1 back-reference, 2 end of block, 3 dropped |
| in_byte | input | 8 | Literal byte for kind 0 |
| in_offset | input | 16 | Back-reference distance for kind 1 |
| in_mlen | input | 16 | Back-reference length for kind 1 |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the block |

## Verification
Short directed blocks pin down exact byte images. An empty block checks the single zero token. Three literals with a four-byte copy check the plain nibble packing. Runs of exactly 15 and 300 literals, with copy lengths of 19 and 274, check both extensions at their zero-remainder and full-255 boundaries. A block that mixes dropped back-references of every invalid kind tells discarding apart from half-applied encoding. A run that fills the literal store tests the refusal and the size bound. Random blocks under random backpressure mix literal runs, short and long copies, and invalid commands. They are compared byte for byte with a packing model, and the output is decoded again, which tells reordering, miscounted extensions and stalled-byte corruption apart.

// File: rtl/lz4_seq_pkg.sv
package lz4_seq_pkg;

  // command codes on in_kind
  typedef enum logic [1:0] {
    K_LIT   = 2'd0,
    K_MATCH = 2'd1,
    K_END   = 2'd2,
    K_NONE  = 2'd3
  } cmd_kind_e;

  // output field currently being written
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_TOKEN  = 3'd1,
    S_LEXT   = 3'd2,
    S_LITS   = 3'd3,
    S_OFS_LO = 3'd4,
    S_OFS_HI = 3'd5,
    S_MEXT   = 3'd6
  } emit_state_e;

  localparam int unsigned NIB_SAT = 15;
  localparam int unsigned EXT_STEP = 255;
  localparam int unsigned MIN_MATCH = 4;

endpackage

// File: rtl/lz4_seq_lit_store.sv
module lz4_seq_lit_store #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + AW'(1);
    if (pop)  rd_d = rd_q + AW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CW'(1)));

endmodule

// File: rtl/lz4_seq_ext_gen.sv
module lz4_seq_ext_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [7:0]   ext_byte,
  output logic         ext_final
);
  import lz4_seq_pkg::*;

  logic [W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = load_val;
    else if (step) rem_d = rem_q - W'(EXT_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign ext_final = (rem_q < W'(EXT_STEP));
  assign ext_byte  = ext_final ? rem_q[7:0] : 8'hFF;

  p_ext_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !ext_final) |=> (rem_q < $past(rem_q)));

endmodule

// File: rtl/lz4_seq_ctrl.sv
module lz4_seq_ctrl #(
  parameter int unsigned LIT_DEPTH = 512,
  parameter int unsigned OFS_LIMIT = 65535,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned CW        = 10,
  parameter int unsigned EXT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [15:0]      in_offset,
  input  logic [LEN_W-1:0] in_mlen,
  input  logic [CW-1:0]    lit_count,
  input  logic [7:0]       lit_head,
  output logic             push,
  output logic             pop,
  input  logic [7:0]       ext_byte,
  input  logic             ext_final,
  output logic             ext_load,
  output logic [EXT_W-1:0] ext_val,
  output logic             ext_step,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  import lz4_seq_pkg::*;

  emit_state_e      st_q, st_d;
  logic [15:0]      ofs_q, ofs_d;
  logic [LEN_W-1:0] ml_q, ml_d;
  logic             fin_q, fin_d;

  logic       lit_room, match_ok, accept, fire;
  logic       lit_big, ml_big;
  logic [3:0] lit_nib, ml_nib;

  assign lit_room = (lit_count < CW'(LIT_DEPTH));
  assign match_ok = (in_offset != 16'd0) && (32'(in_offset) < OFS_LIMIT)
                    && (in_mlen >= LEN_W'(MIN_MATCH));
  assign lit_big  = (lit_count >= CW'(NIB_SAT));
  assign ml_big   = (ml_q >= LEN_W'(NIB_SAT));
  assign lit_nib  = lit_big ? 4'hF : lit_count[3:0];
  assign ml_nib   = fin_q ? 4'h0 : (ml_big ? 4'hF : ml_q[3:0]);
  assign fire     = out_valid && out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    st_d      = st_q;
    ofs_d     = ofs_q;
    ml_d      = ml_q;
    fin_d     = fin_q;
    in_ready  = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    ext_load  = 1'b0;
    ext_val   = '0;
    ext_step  = 1'b0;
    out_valid = (st_q != S_IDLE);
    out_data  = 8'h00;
    out_last  = 1'b0;
    case (st_q)
      S_IDLE: begin
        in_ready = (in_kind == K_LIT) ? lit_room : 1'b1;
        if (accept) begin
          case (in_kind)
            K_LIT:   push = 1'b1;
            K_MATCH: if (match_ok) begin
              ofs_d = in_offset;
              ml_d  = in_mlen - LEN_W'(MIN_MATCH);
              fin_d = 1'b0;
              st_d  = S_TOKEN;
            end
            K_END: begin
              fin_d = 1'b1;
              st_d  = S_TOKEN;
            end
            default: ;
          endcase
        end
      end
      S_TOKEN: begin
        out_data = {lit_nib, ml_nib};
        out_last = fin_q && (lit_count == '0);
        if (fire) begin
          if (lit_big) begin
            ext_load = 1'b1;
            ext_val  = EXT_W'(lit_count - CW'(NIB_SAT));
            st_d     = S_LEXT;
          end else if (lit_count != '0) begin
            st_d = S_LITS;
          end else begin
            st_d = fin_q ? S_IDLE : S_OFS_LO;
          end
        end
      end
      S_LEXT: begin
        out_data = ext_byte;
        if (fire) begin
          ext_step = 1'b1;
          if (ext_final) st_d = S_LITS;
        end
      end
      S_LITS: begin
        out_data = lit_head;
        out_last = fin_q && (lit_count == CW'(1));
        if (fire) begin
          pop = 1'b1;
          if (lit_count == CW'(1)) st_d = fin_q ? S_IDLE : S_OFS_LO;
        end
      end
      S_OFS_LO: begin
        out_data = ofs_q[7:0];
        if (fire) st_d = S_OFS_HI;
      end
      S_OFS_HI: begin
        out_data = ofs_q[15:8];
        if (fire) begin
          if (ml_big) begin
            ext_load = 1'b1;
            ext_val  = EXT_W'(ml_q - LEN_W'(NIB_SAT));
            st_d     = S_MEXT;
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      S_MEXT: begin
        out_data = ext_byte;
        if (fire) begin
          ext_step = 1'b1;
          if (ext_final) st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ofs_q <= '0;
      ml_q  <= '0;
      fin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ofs_q <= ofs_d;
      ml_q  <= ml_d;
      fin_q <= fin_d;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=>
      (st_q == S_IDLE && lit_count == '0));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && in_valid && in_kind == 2'd1 &&
     (in_mlen < LEN_W'(MIN_MATCH) || in_offset == 16'd0)) |=> !out_valid);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !in_ready);

endmodule

// File: rtl/lz4_seq_packer.sv
module lz4_seq_packer #(
  parameter int unsigned LIT_DEPTH = 512,
  parameter int unsigned OFS_LIMIT = 65535,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [7:0]       in_byte,
  input  logic [15:0]      in_offset,
  input  logic [LEN_W-1:0] in_mlen,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);

  localparam int unsigned CW    = $clog2(LIT_DEPTH) + 1;
  localparam int unsigned EXT_W = (CW > LEN_W) ? CW : LEN_W;

  logic             push, pop;
  logic [7:0]       lit_head;
  logic [CW-1:0]    lit_count;
  logic             ext_load, ext_step, ext_final;
  logic [EXT_W-1:0] ext_val;
  logic [7:0]       ext_byte;

  lz4_seq_lit_store #(.DEPTH(LIT_DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_byte),
    .pop       (pop),
    .head      (lit_head),
    .count     (lit_count)
  );

  lz4_seq_ext_gen #(.W(EXT_W)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ext_load),
    .load_val  (ext_val),
    .step      (ext_step),
    .ext_byte  (ext_byte),
    .ext_final (ext_final)
  );

  lz4_seq_ctrl #(
    .LIT_DEPTH (LIT_DEPTH),
    .OFS_LIMIT (OFS_LIMIT),
    .LEN_W     (LEN_W),
    .CW        (CW),
    .EXT_W     (EXT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_offset (in_offset),
    .in_mlen   (in_mlen),
    .lit_count (lit_count),
    .lit_head  (lit_head),
    .push      (push),
    .pop       (pop),
    .ext_byte  (ext_byte),
    .ext_final (ext_final),
    .ext_load  (ext_load),
    .ext_val   (ext_val),
    .ext_step  (ext_step),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

endmodule

// File: tb/lz4_seq_packer_tb.sv
`timescale 1ns/1ps
module lz4_seq_packer_tb;

  localparam int DEPTH  = 512;
  localparam int OLIMIT = 65535;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [1:0]  in_kind;
  logic [7:0]  in_byte;
  logic [15:0] in_offset, in_mlen;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;

  always #2.5 clk = ~clk;

  lz4_seq_packer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_byte(in_byte), .in_offset(in_offset),
    .in_mlen(in_mlen), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int total = 0;
  int bad   = 0;
  bit bp_en = 1'b0;

  int         cmd_k[$];
  logic [7:0] cmd_b[$];
  int         cmd_o[$];
  int         cmd_l[$];
  logic [7:0] src_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] dec_q[$];
  int nlast, last_pos, holdbad, busybad;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic bit ok_match(input int off, input int len);
    return (off != 0) && (off < OLIMIT) && (len >= 4);
  endfunction

  task automatic clear_block();
    cmd_k.delete(); cmd_b.delete(); cmd_o.delete(); cmd_l.delete(); src_q.delete();
  endtask

  task automatic add_lit(input logic [7:0] b);
    cmd_k.push_back(0); cmd_b.push_back(b); cmd_o.push_back(0); cmd_l.push_back(0);
    src_q.push_back(b);
  endtask

  task automatic add_match(input int off, input int len);
    cmd_k.push_back(1); cmd_b.push_back(8'h00); cmd_o.push_back(off); cmd_l.push_back(len);
    if (ok_match(off, len))
      for (int k = 0; k < len; k++) src_q.push_back(src_q[src_q.size() - off]);
  endtask

  task automatic add_cmd(input int kind, input int off, input int len);
    cmd_k.push_back(kind); cmd_b.push_back(8'h00); cmd_o.push_back(off); cmd_l.push_back(len);
  endtask

  task automatic push_ext(input int v);
    int r = v;
    while (r >= 255) begin exp_q.push_back(8'hFF); r -= 255; end
    exp_q.push_back(8'(r));
  endtask

  // packing model built from the requirement text
  task automatic build_expected();
    logic [7:0] pend[$];
    exp_q.delete();
    for (int i = 0; i < cmd_k.size(); i++) begin
      if (cmd_k[i] == 0) pend.push_back(cmd_b[i]);
      else if (cmd_k[i] == 1 || cmd_k[i] == 2) begin
        bit fin = (cmd_k[i] == 2);
        int n = pend.size();
        int ml = cmd_l[i] - 4;
        if (fin || ok_match(cmd_o[i], cmd_l[i])) begin
          int ln = (n >= 15) ? 15 : n;
          int mn = fin ? 0 : ((ml >= 15) ? 15 : ml);
          exp_q.push_back(8'((ln << 4) | mn));
          if (n >= 15) push_ext(n - 15);
          foreach (pend[j]) exp_q.push_back(pend[j]);
          pend.delete();
          if (!fin) begin
            exp_q.push_back(8'(cmd_o[i] & 255));
            exp_q.push_back(8'(cmd_o[i] >> 8));
            if (ml >= 15) push_ext(ml - 15);
          end
        end
      end
    end
  endtask

  // standard block decoder applied to the captured output
  task automatic decode_got();
    int p = 0;
    dec_q.delete();
    while (p < got_q.size()) begin
      int tok = got_q[p]; int n; int ml; int off; int e;
      p++;
      n = tok >> 4;
      if (n == 15) begin
        do begin e = (p < got_q.size()) ? int'(got_q[p]) : 0; p++; n += e; end while (e == 255);
      end
      for (int k = 0; k < n && p < got_q.size(); k++) begin dec_q.push_back(got_q[p]); p++; end
      if (p >= got_q.size()) break;
      off = int'(got_q[p]) | (int'(got_q[p+1]) << 8);
      p += 2;
      ml = tok & 15;
      if (ml == 15) begin
        do begin e = (p < got_q.size()) ? int'(got_q[p]) : 0; p++; ml += e; end while (e == 255);
      end
      ml += 4;
      for (int k = 0; k < ml; k++)
        dec_q.push_back((off >= 1 && off <= dec_q.size()) ? dec_q[dec_q.size() - off] : 8'hXX);
    end
  endtask

  task automatic run_block(input int start);
    int idx = start;
    int guard = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;
    got_q.delete(); nlast = 0; last_pos = -1; holdbad = 0; busybad = 0;
    while (!(idx >= cmd_k.size() && nlast > 0) && guard < 40000) begin
      @(negedge clk);
      guard++;
      out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
      if (idx < cmd_k.size() && (!bp_en || ($urandom % 5) != 0)) begin
        in_valid  = 1'b1;
        in_kind   = 2'(cmd_k[idx]);
        in_byte   = cmd_b[idx];
        in_offset = 16'(cmd_o[idx]);
        in_mlen   = 16'(cmd_l[idx]);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (prev_stall && (!out_valid || out_data != prev_data)) holdbad++;
      if (out_valid && in_ready) busybad++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        got_q.push_back(out_data);
        if (out_last) begin nlast++; last_pos = got_q.size() - 1; end
      end
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(guard < 40000, "R1 block completes", guard, 0);
  endtask

  task automatic check_block(input string name);
    int mis = -1;
    build_expected();
    chk(got_q.size() == exp_q.size(), {"R1 length ", name}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (mis < 0 && got_q[i] !== exp_q[i]) mis = i;
    chk(mis < 0, {"R4 bytes ", name}, (mis < 0) ? 0 : got_q[mis], (mis < 0) ? 0 : exp_q[mis]);
    chk(nlast == 1 && last_pos == got_q.size() - 1, {"R5 last flag ", name}, last_pos, got_q.size() - 1);
    chk(holdbad == 0, {"R8 hold ", name}, holdbad, 0);
    chk(busybad == 0, {"R7 busy ", name}, busybad, 0);
    decode_got();
    mis = (dec_q.size() == src_q.size()) ? -1 : 0;
    for (int i = 0; i < dec_q.size() && i < src_q.size(); i++)
      if (mis < 0 && dec_q[i] !== src_q[i]) mis = i;
    chk(mis < 0, {"R11 round trip ", name}, dec_q.size(), src_q.size());
  endtask

  task automatic gen_random_block(input int nops);
    int pend_n = 0;
    clear_block();
    for (int k = 0; k < nops; k++) begin
      int r = $urandom % 10;
      if (pend_n > 400) r = 7;
      if (r < 6 || src_q.size() == 0) begin
        int run = 1 + ($urandom % 8);
        for (int j = 0; j < run; j++) add_lit(8'($urandom));
        pend_n += run;
      end else if (r < 9) begin
        int lim = (src_q.size() < 1000) ? src_q.size() : 1000;
        int off = 1 + ($urandom % lim);
        int len = 4 + ((($urandom % 8) == 0) ? ($urandom % 400) : ($urandom % 20));
        add_match(off, len);
        pend_n = 0;
      end else begin
        case ($urandom % 4)
          0: add_match(0, 8);
          1: add_match(OLIMIT, 8);
          2: add_match(1, 3);
          default: add_cmd(3, 0, 0);
        endcase
      end
    end
    add_cmd(2, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd13579));
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'd0; in_byte = 8'h00;
    in_offset = 16'h0; in_mlen = 16'h0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R10 reset literal ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 after release", out_valid, 0);

    // empty block: single zero token
    clear_block(); add_cmd(2, 0, 0);
    run_block(0); check_block("empty");
    chk(got_q.size() == 1 && got_q[0] == 8'h00, "R5 empty close", got_q.size(), 1);

    // short literal run and a minimum copy
    clear_block(); add_lit(8'h61); add_lit(8'h62); add_lit(8'h63); add_match(3, 4); add_cmd(2, 0, 0);
    run_block(0); check_block("short");
    chk(got_q.size() > 5 && got_q[0] == 8'h30, "R2 token 0x30", got_q[0], 8'h30);
    chk(got_q.size() > 5 && got_q[4] == 8'h03 && got_q[5] == 8'h00, "R1 offset low first", got_q[4], 3);

    // extension boundaries
    clear_block();
    for (int i = 0; i < 15; i++) add_lit(8'(i + 1));
    add_match(1, 19);
    for (int i = 0; i < 300; i++) add_lit(8'(i * 7));
    add_match(2, 274);
    add_cmd(2, 0, 0);
    run_block(0); check_block("ext");
    chk(got_q.size() > 326 && got_q[0] == 8'hFF && got_q[1] == 8'h00, "R3 lit ext 15", got_q[1], 0);
    chk(got_q.size() > 326 && got_q[19] == 8'h00, "R3 match ext 19", got_q[19], 0);
    chk(got_q.size() > 326 && got_q[20] == 8'hFF && got_q[21] == 8'hFF && got_q[22] == 8'd30,
        "R3 lit ext 300", got_q[22], 30);
    chk(got_q.size() > 326 && got_q[325] == 8'hFF && got_q[326] == 8'h00, "R3 match ext 274", got_q[326], 0);

    // dropped back-references
    clear_block();
    for (int i = 0; i < 5; i++) add_lit(8'(8'hA0 + i));
    add_match(0, 8); add_match(4, 3); add_match(OLIMIT, 9); add_cmd(3, 0, 0);
    add_cmd(2, 0, 0);
    run_block(0); check_block("drop");
    chk(got_q.size() == 6 && got_q[0] == 8'h50, "R6 drop leaves literals", got_q.size(), 6);

    // full literal store
    clear_block();
    for (int i = 0; i < DEPTH; i++) add_lit(8'($urandom));
    add_cmd(2, 0, 0);
    begin
      int idx = 0;
      while (idx < DEPTH) begin
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'd0; in_byte = cmd_b[idx];
        #1;
        if (in_ready) idx++;
      end
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'd0; in_byte = 8'h55;
        #1;
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R7 full store refuses", in_ready, 0);
      end
    end
    run_block(DEPTH); check_block("full");
    chk(got_q.size() <= DEPTH + DEPTH / 255 + 16, "R9 size bound", got_q.size(), DEPTH + DEPTH / 255 + 16);

    // random blocks under backpressure
    bp_en = 1'b1;
    for (int b = 0; b < 16; b++) begin
      gen_random_block(40);
      run_block(0);
      check_block($sformatf("random%0d", b));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule